// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one 16-bit up-counting timer channel with a small register file reached over a single-cycle bus. A prescaler divides the system clock by 1, 4, 16 or 64 to make counting ticks. The counter advances on each tick while the channel's own bit in an externally held start vector is set. When the counter sits at the value of compare register A as a tick arrives, a compare event occurs. That event raises a status flag, can raise an interrupt, can reset the counter, and can drive a single output pin.

The flag follows a read-then-write-zero handshake, so a stray write cannot lose an event that software has not yet seen. The counter can be cleared by its own compare event, by a peer-clear input from neighbouring channels, or not at all. The pin action code also sets the pin's starting level when it is written, which gives a periodic waveform with a known phase.

Top module: `cmt_channel`

## Requirements
- R1: After reset the counter reads 0x0000, compare A reads 0xFFFF, the control and status registers read 0, and both `irq` and `pin_out` are 0.
- R2: Control bits 2:0 select the tick rate. Code 0 gives a tick every cycle, 1 every 4 cycles, 2 every 16 cycles and 3 every 64 cycles. The counter advances by one per tick.
- R3: With control bits 7:5 = 1, a tick that finds the counter equal to compare A sets the counter to 0 and sets status bit 0, so a full period is (compare A + 1) ticks. The flag is set even when the interrupt is disabled.
- R4: With control bits 7:5 = 0, the counter never clears by itself and rolls from 0xFFFF to 0x0000.
- R5: The counter changes only while bit CH_IDX of `start_vec` is 1. Other bits of `start_vec` have no effect, and clearing the bit freezes the count.
- R6: While the start bit is 0 the prescaler is held at its initial state, so the first tick after a start comes exactly one full divide period later.
- R7: Status bit 0 is cleared only by writing 0 to it at offset 5 after it has been read as 1. Writing 0 without that read, or writing 1, leaves it set.
- R8: `irq` equals status bit 0 ANDed with bit 0 of the interrupt-enable register at offset 4.
- R9: The low nibble of the pin-control register (offset 2) sets the pin action. Codes 1, 2 and 3 load the pin with 0 when written; codes 5, 6 and 7 load it with 1. On a compare event, codes ending in binary 01 drive the pin to 0, 10 drive it to 1, and 11 invert it. Code 0 leaves the pin unchanged.
- R10: A nonzero value in mode bits 3:0 (offset 1) suppresses compare events: the flag does not set and the counter is not cleared, but it keeps counting.
- R11: A bus write to the counter (offset 6) takes effect in place of a tick increment in the same cycle.
- R12: Control bits 7:5 = 3 clear the counter in any cycle where `peer_clr` is 1. Under other clear codes `peer_clr` is ignored. Clear codes 2, 5 and 6 behave as no clear.
- R13: Prescale codes 4 to 7 produce no ticks, so the counter stays put.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset: 0 control, 1 mode, 2 pin control, 4 interrupt enable, 5 status, 6 counter, 8 compare A |
| bus_wdata | input | 16 | Write data; byte registers use bits 7:0 |
| bus_rdata | output | 16 | Read data for the addressed register, valid in the same cycle |
| start_vec | input | NCH | Shared start vector; bit CH_IDX runs this channel |
| peer_clr | input | 1 | Synchronous clear request from neighbouring channels |
| irq | output | 1 | Compare A interrupt request |
| pin_out | output | 1 | Compare output pin |

## Verification
Register writes, tick increments, flag changes and pin changes all appear on the rising edge that follows the cycle that caused them. Read data and `irq` are combinational and therefore valid within the same cycle. The bench drives every input just after a falling edge and samples 1 ns later, and it counts rising edges from the moment the start bit rises. From that count it computes the expected counter as floor(edges / divisor) modulo (compare + 1), and it places the flag check exactly one edge after the last edge at which no match is possible. Pin levels are checked on the edge after a control write and on the edge of the fourth tick, where the first compare event falls.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;
    localparam int BUS_W  = 16;
    localparam int ADDR_W = 4;
    localparam int PSCL_W = 6;

    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_MODE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFS_PINC = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] OFS_IEN  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(5);
    localparam logic [ADDR_W-1:0] OFS_CNT  = ADDR_W'(6);
    localparam logic [ADDR_W-1:0] OFS_CMPA = ADDR_W'(8);

    localparam logic [2:0] CLR_ON_A = 3'd1;
    localparam logic [2:0] CLR_PEER = 3'd3;

    typedef struct packed {
        logic [2:0] clr;
        logic [1:0] edg;
        logic [2:0] pscl;
    } ctrl_t;

    typedef struct packed {
        logic [3:0] spare;
        logic [3:0] act;
    } pinc_t;

    typedef enum logic [1:0] {
        PA_HOLD = 2'd0,
        PA_LOW  = 2'd1,
        PA_HIGH = 2'd2,
        PA_FLIP = 2'd3
    } pin_act_t;

    // Last prescaler count before a tick, per rate code.
    function automatic logic [PSCL_W-1:0] pscl_last(input logic [2:0] code);
        case (code)
            3'd1:    return PSCL_W'(3);
            3'd2:    return PSCL_W'(15);
            3'd3:    return PSCL_W'(63);
            default: return '0;
        endcase
    endfunction

    function automatic logic pscl_ok(input logic [2:0] code);
        return !code[2];
    endfunction

    function automatic pin_act_t pin_decode(input logic [3:0] code);
        if (code[3] || code[1:0] == 2'b00) return PA_HOLD;
        return pin_act_t'(code[1:0]);
    endfunction

    function automatic logic pin_has_init(input logic [3:0] code);
        return !code[3] && (code[1:0] != 2'b00);
    endfunction
endpackage

// File: rtl/cmt_prescale.sv
`timescale 1ns/1ps
module cmt_prescale
    import cmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] code,
    output logic       tick
);
    logic [PSCL_W-1:0] pcnt;
    logic [PSCL_W-1:0] last;
    logic              ok;

    assign last = pscl_last(code);
    assign ok   = pscl_ok(code);
    assign tick = run && ok && (pcnt == last);

    // Held at zero while stopped so a restart begins a full period.
    always_ff @(posedge clk) begin
        if (rst || !run || tick) pcnt <= '0;
        else if (ok)             pcnt <= pcnt + 1'b1;
    end

    p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && code != 3'd0) |=> (!tick || code != $past(code)));
endmodule

// File: rtl/cmt_count.sv
`timescale 1ns/1ps
module cmt_count
    import cmt_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         evt_en,
    input  logic [2:0]   clr_sel,
    input  logic         peer_clr,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] cnt,
    output logic         match
);
    logic peer_hit;
    logic self_clr;

    assign match    = tick && evt_en && (cnt == cmp);
    assign peer_hit = (clr_sel == CLR_PEER) && peer_clr;
    assign self_clr = match && (clr_sel == CLR_ON_A);

    always_ff @(posedge clk) begin
        if (rst)           cnt <= '0;
        else if (wr_en)    cnt <= wr_val;
        else if (peer_hit) cnt <= '0;
        else if (tick)     cnt <= self_clr ? '0 : cnt + 1'b1;
    end

    p_clear_on_a_r3: assert property (@(posedge clk) disable iff (rst)
        (match && clr_sel == CLR_ON_A && !wr_en) |=> (cnt == '0));

    p_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_en && !peer_hit) |=> $stable(cnt));

    p_bus_wins_r11: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cnt == $past(wr_val)));
endmodule

// File: rtl/cmt_pin.sv
`timescale 1ns/1ps
module cmt_pin
    import cmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic [3:0] cfg_new,
    input  logic [3:0] cfg_cur,
    input  logic       match,
    output logic       pin
);
    pin_act_t act;

    assign act = pin_decode(cfg_cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin <= 1'b0;
        end else if (cfg_wr) begin
            if (pin_has_init(cfg_new)) pin <= cfg_new[2];
        end else if (match) begin
            case (act)
                PA_LOW:  pin <= 1'b0;
                PA_HIGH: pin <= 1'b1;
                PA_FLIP: pin <= !pin;
                default: pin <= pin;
            endcase
        end
    end

    p_pin_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wr && !match) |=> $stable(pin));

    p_pin_init_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && pin_has_init(cfg_new)) |=> (pin == $past(cfg_new[2])));
endmodule

// File: rtl/cmt_channel.sv
`timescale 1ns/1ps
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NCH-1:0]    start_vec,
    input  logic              peer_clr,
    output logic              irq,
    output logic              pin_out
);
    localparam logic [NCH-1:0] OWN_BIT = NCH'(1) << CH_IDX;

    ctrl_t             ctrl;
    pinc_t             pinc;
    logic [7:0]        mode_r;
    logic [7:0]        ien_r;
    logic [BUS_W-1:0]  cmpa_r;
    logic [BUS_W-1:0]  cnt;
    logic              flag;
    logic              armed;
    logic              run;
    logic              tick;
    logic              match;
    logic              evt_en;
    logic              wr;
    logic              rd;
    logic              stat_rd;
    logic              stat_wr0;

    assign wr       = bus_sel && bus_we;
    assign rd       = bus_sel && !bus_we;
    assign stat_rd  = rd && (bus_addr == OFS_STAT);
    assign stat_wr0 = wr && (bus_addr == OFS_STAT) && !bus_wdata[0];
    assign run      = |(start_vec & OWN_BIT);
    assign evt_en   = (mode_r[3:0] == 4'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            mode_r <= '0;
            pinc   <= '0;
            ien_r  <= '0;
            cmpa_r <= '1;
        end else if (wr) begin
            case (bus_addr)
                OFS_CTRL: ctrl   <= ctrl_t'(bus_wdata[7:0]);
                OFS_MODE: mode_r <= bus_wdata[7:0];
                OFS_PINC: pinc   <= pinc_t'(bus_wdata[7:0]);
                OFS_IEN:  ien_r  <= bus_wdata[7:0];
                OFS_CMPA: cmpa_r <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // Flag handshake: a read seeing 1 arms the clear; a match always wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (match)                  flag <= 1'b1;
            else if (stat_wr0 && armed) flag <= 1'b0;

            if (stat_wr0)             armed <= 1'b0;
            else if (stat_rd && flag) armed <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: bus_rdata[7:0] = ctrl;
            OFS_MODE: bus_rdata[7:0] = mode_r;
            OFS_PINC: bus_rdata[7:0] = pinc;
            OFS_IEN:  bus_rdata[7:0] = ien_r;
            OFS_STAT: bus_rdata[0]   = flag;
            OFS_CNT:  bus_rdata      = cnt;
            OFS_CMPA: bus_rdata      = cmpa_r;
            default:  bus_rdata      = '0;
        endcase
    end

    assign irq = flag && ien_r[0];

    cmt_prescale u_pscl (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .code (ctrl.pscl),
        .tick (tick)
    );

    cmt_count #(.W(BUS_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .evt_en   (evt_en),
        .clr_sel  (ctrl.clr),
        .peer_clr (peer_clr),
        .wr_en    (wr && (bus_addr == OFS_CNT)),
        .wr_val   (bus_wdata),
        .cmp      (cmpa_r),
        .cnt      (cnt),
        .match    (match)
    );

    cmt_pin u_pin (
        .clk     (clk),
        .rst     (rst),
        .cfg_wr  (wr && (bus_addr == OFS_PINC)),
        .cfg_new (bus_wdata[3:0]),
        .cfg_cur (pinc.act),
        .match   (match),
        .pin     (pin_out)
    );

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flag && !(stat_wr0 && armed)) |=> flag);

    p_mode_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (mode_r[3:0] != 4'd0 && !flag) |=> !flag);
endmodule

// File: tb/tb_cmt_channel.sv
`timescale 1ns/1ps
module tb_cmt_channel;
    logic        clk;
    logic        rst;
    logic        sel;
    logic        we;
    logic [3:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [2:0]  start_vec;
    logic        peer_clr;
    logic        irq;
    logic        pin;
    int          n_chk;
    int          n_bad;
    logic        done;
    logic [15:0] v;
    logic [15:0] v2;
    logic [3:0]  code;
    logic        exp_pin;
    int          d;
    int          c;
    int          p;
    int          e;

    cmt_channel #(.NCH(3), .CH_IDX(0)) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (sel),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .start_vec (start_vec),
        .peer_clr  (peer_clr),
        .irq       (irq),
        .pin_out   (pin)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] expv);
        n_chk++;
        if (got !== expv) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, expv);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] dv);
        sel = 1'b1; we = 1'b1; addr = a; wdata = dv;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] rv);
        sel = 1'b1; we = 1'b0; addr = a;
        #1 rv = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [7:0] cv, input logic [15:0] cmpv);
        logic [15:0] s;
        start_vec = 3'b000;
        wr(4'd0, {8'h00, cv});
        wr(4'd1, 16'h0000);
        wr(4'd8, cmpv);
        wr(4'd6, 16'h0000);
        wr(4'd4, 16'h0001);
        rd(4'd5, s);
        if (s[0]) wr(4'd5, 16'h0000);
    endtask

    initial begin
        done = 1'b0; n_chk = 0; n_bad = 0;
        rst = 1'b1; sel = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        start_vec = 3'b000; peer_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'd6, v); chk("R1 counter", v, 16'h0000);
        rd(4'd8, v); chk("R1 compare A", v, 16'hffff);
        rd(4'd0, v); chk("R1 control", v, 16'h0000);
        rd(4'd5, v); chk("R1 status", v, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 pin", {15'd0, pin}, 16'd0);

        // R2 / R3 sweep over all rates and several compare values
        for (int ps = 0; ps < 4; ps++) begin
            for (int k = 0; k < 3; k++) begin
                d = 1 << (2 * ps);
                c = (k == 0) ? 0 : ((k == 1) ? 2 : 5);
                p = d * (c + 1);
                setup(8'h20 | 8'(ps), 16'(c));
                start_vec = 3'b001;
                idle(p - 1);
                chk("R3 irq low before match", {15'd0, irq}, 16'd0);
                rd(4'd6, v); chk("R2 count before match", v, 16'(c));
                chk("R3 irq at match", {15'd0, irq}, 16'd1);
                idle(p + d);
                e = 2 * p + d;
                rd(4'd6, v); chk("R2 count after periods", v, 16'((e / d) % (c + 1)));
            end
        end

        // R5 freeze; other start bits do nothing
        start_vec = 3'b110;
        rd(4'd6, v);
        idle(20);
        rd(4'd6, v2); chk("R5 frozen counter", v2, v);

        // R6 prescaler restarts from zero
        setup(8'h02, 16'hffff);
        start_vec = 3'b001; idle(10);
        start_vec = 3'b000; idle(5);
        start_vec = 3'b001; idle(15);
        rd(4'd6, v); chk("R6 no tick before full period", v, 16'h0000);
        rd(4'd6, v); chk("R6 tick after full period", v, 16'h0001);

        // R4 wrap without clear
        setup(8'h00, 16'h0010);
        wr(4'd6, 16'hfffe);
        start_vec = 3'b001; idle(3);
        rd(4'd6, v); chk("R4 wrap", v, 16'h0001);

        // R13 stopped prescale codes
        setup(8'h05, 16'h0010);
        start_vec = 3'b001; idle(10);
        rd(4'd6, v); chk("R13 code 5 stopped", v, 16'h0000);
        setup(8'h07, 16'h0010);
        start_vec = 3'b001; idle(10);
        rd(4'd6, v); chk("R13 code 7 stopped", v, 16'h0000);

        // R11 bus write beats increment
        setup(8'h00, 16'hffff);
        start_vec = 3'b001; idle(4);
        wr(4'd6, 16'h0100);
        rd(4'd6, v); chk("R11 write value", v, 16'h0100);
        rd(4'd6, v); chk("R11 counting resumes", v, 16'h0101);

        // R10 non-normal mode suppresses events
        setup(8'h20, 16'h0003);
        wr(4'd1, 16'h0002);
        start_vec = 3'b001; idle(6);
        rd(4'd6, v); chk("R10 no clear in other mode", v, 16'h0006);
        chk("R10 no flag in other mode", {15'd0, irq}, 16'd0);

        // R12 clear sources
        setup(8'h40, 16'h0003);
        start_vec = 3'b001; idle(6);
        rd(4'd6, v); chk("R12 code 2 acts as no clear", v, 16'h0006);
        chk("R12 flag still set on A match", {15'd0, irq}, 16'd1);
        setup(8'h60, 16'hffff);
        start_vec = 3'b001; idle(5);
        peer_clr = 1'b1; @(negedge clk); peer_clr = 1'b0;
        rd(4'd6, v); chk("R12 peer clear", v, 16'h0000);
        setup(8'h00, 16'hffff);
        start_vec = 3'b001; idle(5);
        peer_clr = 1'b1; @(negedge clk); peer_clr = 1'b0;
        rd(4'd6, v); chk("R12 peer clear ignored", v, 16'h0006);

        // R7 / R8 flag handshake and interrupt gating
        setup(8'h20, 16'h0001);
        wr(4'd4, 16'h0000);
        start_vec = 3'b001; idle(2);
        start_vec = 3'b000;
        chk("R8 irq masked", {15'd0, irq}, 16'd0);
        wr(4'd5, 16'h0000);
        rd(4'd5, v); chk("R7 write 0 without read", v, 16'h0001);
        wr(4'd5, 16'h0001);
        rd(4'd5, v); chk("R7 write 1 keeps flag", v, 16'h0001);
        wr(4'd4, 16'h0001);
        chk("R8 irq enabled", {15'd0, irq}, 16'd1);
        wr(4'd5, 16'h0000);
        rd(4'd5, v); chk("R7 read then write 0 clears", v, 16'h0000);
        chk("R8 irq after clear", {15'd0, irq}, 16'd0);

        // R9 pin actions
        for (int i = 0; i < 6; i++) begin
            code = (i < 3) ? 4'(i + 1) : 4'(i + 2);
            setup(8'h20, 16'h0003);
            wr(4'd2, {12'd0, code});
            chk("R9 initial level", {15'd0, pin}, {15'd0, code[2]});
            start_vec = 3'b001; idle(4);
            exp_pin = (code[1:0] == 2'b01) ? 1'b0 :
                      (code[1:0] == 2'b10) ? 1'b1 : !code[2];
            chk("R9 level after match", {15'd0, pin}, {15'd0, exp_pin});
        end
        start_vec = 3'b000;
        wr(4'd2, 16'h0006);
        wr(4'd2, 16'h0000);
        chk("R9 code 0 keeps level on write", {15'd0, pin}, 16'd1);
        setup(8'h20, 16'h0003);
        start_vec = 3'b001; idle(8);
        chk("R9 code 0 keeps level on match", {15'd0, pin}, 16'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule